// File: doc/BRIEF.md
# Split-Transaction Tracking Table

This block sits in a hub-side translator between a high-speed host and a full/low-speed downstream bus. It keeps a table of split transactions in flight. Each start-split token from the host creates an entry keyed by its pipe: device address, endpoint, direction and transfer type. A simplified downstream-bus model then reports when each entry's packet starts and how it finishes. When the host later sends a complete-split token, the block looks the pipe up in the table and emulates the handshake the host should see.

Periodic pipes (isochronous, interrupt) use a partition of `PERIODIC_PIPES` slots, and that parameter must be 4 or 16. Control and bulk pipes use a separate two-slot partition. Stale entries are removed by timing rules rather than by arrival order:
- A periodic start-split that has not begun on the downstream bus is dropped at the end of a frame, or when the frame reaches microframe 6.
- Any entry left untouched for too many microframes is dropped.

For the two asynchronous slots, a length estimate decides whether a packet could still finish before the next start of frame. The downstream model may only launch an asynchronous packet when that estimate allows it.

Top module: `tt_split_tracker`

## Requirements
- R1: A start-split token (tok_kind=0) is always answered with code 0 (no handshake). If no live entry has the same pipe key, the token takes the lowest free slot of its partition. That slot's bit in slot_live rises on the next cycle and the entry becomes pending. Periodic types (tok_type 01 iso, 11 interrupt) use slots 0..PERIODIC_PIPES-1, and types 00 (control) and 10 (bulk) use the two slots after them. A start-split whose key is already live allocates nothing and resets that entry's idle age.
- R2: A start-split that finds its partition full is dropped and leaves every entry unchanged. It sets ovf_sticky, which stays high until reset.
- R3: A complete-split (tok_kind=1) whose key matches no live entry is answered with code 1 (bus time-out).
- R4: A complete-split that matches a pending or busy entry is answered with code 2 (NYET). It resets the entry's idle age and leaves the entry live.
- R5: A complete-split that matches a finished entry is answered with the recorded outcome, then the entry is freed. The codes are 3 for ACK, 4 for NAK and 5 for STALL.
- R6: dn_start on a pending slot makes it busy. dn_done with dn_done_hs (0 ACK, 1 NAK, 2 STALL) on a busy slot makes it finished and records the outcome. Either event on a slot in any other state is ignored. Both events reset the entry's idle age.
- R7: uf_num counts microframe strobes modulo 8. On a strobe that moves uf_num from 7 to 0 (end of frame), or from 5 to ABORT_UFRAME=6, every pending periodic entry is freed. Busy entries are kept.
- R8: Each strobe ages every live entry. An entry left untouched for AGE_LIMIT=4 strobes stays live, and it is freed on the fifth untouched strobe.
- R9: async_start_ok[j] is high when asynchronous slot j is pending and len*8 + len/2 + 64 ≤ bus_time_left. A dn_start on an asynchronous slot while this signal is low is ignored.
- R10: hs_valid is high for exactly the cycle after each token, with hs_code valid in that cycle.
- R11: An entry that a token or downstream event touches in the same cycle as a strobe takes that event's result with idle age 0, and none of the strobe's abort rules apply to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uframe_tick | input | 1 | Microframe strobe |
| tok_valid | input | 1 | Split token present |
| tok_kind | input | 1 | 0 start-split, 1 complete-split |
| tok_addr | input | 7 | Device address |
| tok_ep | input | 4 | Endpoint number |
| tok_dir | input | 1 | Direction |
| tok_type | input | 2 | 00 control, 01 iso, 10 bulk, 11 interrupt |
| tok_len | input | LEN_W | Payload bytes (asynchronous start-splits) |
| dn_start_valid | input | 1 | Downstream packet started |
| dn_start_slot | input | SW | Slot that started |
| dn_done_valid | input | 1 | Downstream packet finished |
| dn_done_slot | input | SW | Slot that finished |
| dn_done_hs | input | 2 | Outcome: 0 ACK, 1 NAK, 2 STALL |
| bus_time_left | input | TIME_W | Bit times left before start of frame |
| hs_valid | output | 1 | Emulated handshake valid |
| hs_code | output | 3 | 0 none, 1 time-out, 2 NYET, 3 ACK, 4 NAK, 5 STALL |
| slot_live | output | NT | Per-slot occupied flags |
| async_start_ok | output | 2 | Asynchronous slot may be launched |
| ovf_sticky | output | 1 | A start-split was dropped on a full partition |
| uf_num | output | 3 | Current microframe number |

## Verification
The bench targets the boundary of the idle-age window. If that window is off by one, the entry is freed one strobe early or survives one strobe late, and slot_live shows the difference. It also drives a complete-split in the same cycle as a strobe that would otherwise age out the matching entry. A design that applies the strobe anyway loses the entry and later answers with time-out instead of NYET.

The frame rules are tested at both abort points and with a busy periodic entry that must survive them. The length estimate is tested at exactly its threshold, where an inverted or strict comparison shows up on async_start_ok. Overflow is tested with a full partition, where a design that overwrites an entry would lose a pipe that a following complete-split still expects to find.

// File: rtl/tt_split_pkg.sv
`timescale 1ns/1ps
package tt_split_pkg;
   typedef enum logic [1:0] {
      ST_FREE = 2'd0,
      ST_PEND = 2'd1,
      ST_BUSY = 2'd2,
      ST_DONE = 2'd3
   } slot_state_e;

   localparam logic [2:0] HS_NONE    = 3'd0;
   localparam logic [2:0] HS_TIMEOUT = 3'd1;
   localparam logic [2:0] HS_NYET    = 3'd2;
   localparam logic [2:0] HS_ACK     = 3'd3;

   // address(7) + endpoint(4) + direction(1) + type(2)
   localparam int KEY_W = 14;
endpackage

// File: rtl/tt_slot_alloc.sv
`timescale 1ns/1ps
// Lowest-index finder over a request vector.
module tt_slot_alloc #(
   parameter int N  = 4,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = |req;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/tt_pipe_match.sv
`timescale 1ns/1ps
// Parallel key compare of a probe against every live table entry.
module tt_pipe_match #(
   parameter int N  = 4,
   parameter int KW = 14
) (
   input  logic [N-1:0]         live,
   input  logic [N-1:0][KW-1:0] keys,
   input  logic [KW-1:0]        probe,
   output logic [N-1:0]         hit
);
   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign hit[g] = live[g] && (keys[g] == probe);
   end
endmodule

// File: rtl/tt_async_budget.sv
`timescale 1ns/1ps
// Per-slot bus-time estimate for asynchronous packets against time left before SOF.
module tt_async_budget #(
   parameter int NA           = 2,
   parameter int LEN_W        = 11,
   parameter int TIME_W       = 16,
   parameter int OVH          = 64,
   parameter bit STUFF_MARGIN = 1'b1
) (
   input  logic [NA-1:0]            pend,
   input  logic [NA-1:0][LEN_W-1:0] len,
   input  logic [TIME_W-1:0]        time_left,
   output logic [NA-1:0]            ok
);
   localparam int CW = (((LEN_W + 4) > TIME_W) ? (LEN_W + 4) : TIME_W) + 1;

   for (genvar g = 0; g < NA; g++) begin : g_slot
      logic [CW-1:0] base;
      logic [CW-1:0] stuff;
      logic [CW-1:0] est;
      assign base = CW'(len[g]) << 3;
      if (STUFF_MARGIN) begin : g_stuff
         assign stuff = CW'(len[g]) >> 1;
      end else begin : g_plain
         assign stuff = '0;
      end
      assign est   = base + stuff + CW'(OVH);
      assign ok[g] = pend[g] && (est <= CW'(time_left));
   end
endmodule

// File: rtl/tt_split_tracker.sv
`timescale 1ns/1ps
module tt_split_tracker
   import tt_split_pkg::*;
#(
   parameter int PERIODIC_PIPES = 16,
   parameter int ASYNC_PIPES    = 2,
   parameter int AGE_LIMIT      = 4,
   parameter int ABORT_UFRAME   = 6,
   parameter int LEN_W          = 11,
   parameter int TIME_W         = 16,
   parameter int PKT_OVH        = 64,
   parameter bit STUFF_MARGIN   = 1'b1,
   localparam int NT            = PERIODIC_PIPES + ASYNC_PIPES,
   localparam int SW            = $clog2(NT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              uframe_tick,
   input  logic              tok_valid,
   input  logic              tok_kind,
   input  logic [6:0]        tok_addr,
   input  logic [3:0]        tok_ep,
   input  logic              tok_dir,
   input  logic [1:0]        tok_type,
   input  logic [LEN_W-1:0]  tok_len,
   input  logic              dn_start_valid,
   input  logic [SW-1:0]     dn_start_slot,
   input  logic              dn_done_valid,
   input  logic [SW-1:0]     dn_done_slot,
   input  logic [1:0]        dn_done_hs,
   input  logic [TIME_W-1:0] bus_time_left,
   output logic              hs_valid,
   output logic [2:0]        hs_code,
   output logic [NT-1:0]     slot_live,
   output logic [1:0]        async_start_ok,
   output logic              ovf_sticky,
   output logic [2:0]        uf_num
);
   localparam int NP    = PERIODIC_PIPES;
   localparam int NA    = ASYNC_PIPES;
   localparam int PIW   = $clog2(NP);
   localparam int AIW   = (NA > 1) ? $clog2(NA) : 1;
   localparam int AGE_W = $clog2(AGE_LIMIT + 1);

   // elaboration-time configuration checks
   if (!(PERIODIC_PIPES == 4 || PERIODIC_PIPES == 16)) begin : g_bad_periodic
      $error("PERIODIC_PIPES must be 4 or 16");
   end
   if (ASYNC_PIPES != 2) begin : g_bad_async
      $error("ASYNC_PIPES must be 2");
   end
   if (ABORT_UFRAME < 1 || ABORT_UFRAME > 7) begin : g_bad_abort
      $error("ABORT_UFRAME must lie in 1..7");
   end

   slot_state_e               st_q   [NT];
   slot_state_e               st_d   [NT];
   logic [AGE_W-1:0]          age_q  [NT];
   logic [AGE_W-1:0]          age_d  [NT];
   logic [1:0]                rec_q  [NT];
   logic [1:0]                rec_d  [NT];
   logic [NT-1:0][KEY_W-1:0]  key_q, key_d;
   logic [NA-1:0][LEN_W-1:0]  len_q, len_d;
   logic                      ovf_q, ovf_d;
   logic                      hsv_q;
   logic [2:0]                hsc_q, hsc_d;
   logic [2:0]                uf_q;

   logic [NT-1:0]             live;
   logic [NA-1:0]             apend;
   logic [NA-1:0]             aok;
   logic [NT-1:0]             may_start;
   logic [KEY_W-1:0]          tok_key;
   logic [NT-1:0]             hit;
   logic                      hit_found;
   logic [SW-1:0]             hit_idx;
   logic                      p_found, a_found;
   logic [PIW-1:0]            p_idx;
   logic [AIW-1:0]            a_idx;
   logic [2:0]                uf_next;
   logic                      frame_end;
   logic                      late_mark;

   for (genvar g = 0; g < NT; g++) begin : g_live
      assign live[g] = (st_q[g] != ST_FREE);
   end
   for (genvar g = 0; g < NA; g++) begin : g_apend
      assign apend[g] = (st_q[NP + g] == ST_PEND);
   end

   assign tok_key   = {tok_addr, tok_ep, tok_dir, tok_type};
   assign uf_next   = uf_q + 3'd1;
   assign frame_end = uframe_tick && (uf_q == 3'd7);
   assign late_mark = uframe_tick && (uf_next == 3'(ABORT_UFRAME));
   assign may_start = {aok, {NP{1'b1}}};

   tt_pipe_match #(.N(NT), .KW(KEY_W)) u_match (
      .live (live), .keys (key_q), .probe (tok_key), .hit (hit)
   );

   tt_slot_alloc #(.N(NT), .IW(SW)) u_hit_sel (
      .req (hit), .found (hit_found), .idx (hit_idx)
   );

   tt_slot_alloc #(.N(NP), .IW(PIW)) u_per_alloc (
      .req (~live[NP-1:0]), .found (p_found), .idx (p_idx)
   );

   tt_slot_alloc #(.N(NA), .IW(AIW)) u_asy_alloc (
      .req (~live[NT-1:NP]), .found (a_found), .idx (a_idx)
   );

   tt_async_budget #(
      .NA (NA), .LEN_W (LEN_W), .TIME_W (TIME_W),
      .OVH (PKT_OVH), .STUFF_MARGIN (STUFF_MARGIN)
   ) u_budget (
      .pend (apend), .len (len_q), .time_left (bus_time_left), .ok (aok)
   );

   always_comb begin
      slot_state_e hit_st;
      logic [1:0]  hit_rec;
      hit_st  = ST_FREE;
      hit_rec = 2'd0;
      ovf_d   = ovf_q;
      len_d   = len_q;
      key_d   = key_q;
      for (int i = 0; i < NT; i++) begin
         st_d[i]  = st_q[i];
         age_d[i] = age_q[i];
         rec_d[i] = rec_q[i];
      end

      // microframe strobe: ageing and periodic start aborts
      if (uframe_tick) begin
         for (int i = 0; i < NT; i++) begin
            if (st_q[i] != ST_FREE) begin
               if (age_q[i] >= AGE_W'(AGE_LIMIT)) st_d[i] = ST_FREE;
               else age_d[i] = age_q[i] + AGE_W'(1);
               if (i < NP && st_q[i] == ST_PEND && (frame_end || late_mark))
                  st_d[i] = ST_FREE;
            end
         end
      end

      // downstream events, then token (token wins on a shared slot)
      for (int i = 0; i < NT; i++) begin
         if (dn_start_valid && dn_start_slot == SW'(i) && st_q[i] == ST_PEND
             && may_start[i]) begin
            st_d[i]  = ST_BUSY;
            age_d[i] = '0;
         end
         if (dn_done_valid && dn_done_slot == SW'(i) && st_q[i] == ST_BUSY) begin
            st_d[i]  = ST_DONE;
            rec_d[i] = dn_done_hs;
            age_d[i] = '0;
         end
         if (tok_valid && hit_found && hit_idx == SW'(i)) begin
            hit_st   = st_q[i];
            hit_rec  = rec_q[i];
            age_d[i] = '0;
            st_d[i]  = (tok_kind && st_q[i] == ST_DONE) ? ST_FREE : st_q[i];
         end
      end

      // allocation of a new start-split
      if (tok_valid && !tok_kind && !hit_found) begin
         if (tok_type[0]) begin
            if (p_found) begin
               for (int i = 0; i < NP; i++) begin
                  if (p_idx == PIW'(i)) begin
                     st_d[i]  = ST_PEND;
                     age_d[i] = '0;
                     rec_d[i] = 2'd0;
                     key_d[i] = tok_key;
                  end
               end
            end else begin
               ovf_d = 1'b1;
            end
         end else begin
            if (a_found) begin
               for (int j = 0; j < NA; j++) begin
                  if (a_idx == AIW'(j)) begin
                     st_d[NP + j]  = ST_PEND;
                     age_d[NP + j] = '0;
                     rec_d[NP + j] = 2'd0;
                     key_d[NP + j] = tok_key;
                     len_d[j]      = tok_len;
                  end
               end
            end else begin
               ovf_d = 1'b1;
            end
         end
      end

      // handshake emulation
      if (!tok_kind)                 hsc_d = HS_NONE;
      else if (!hit_found)           hsc_d = HS_TIMEOUT;
      else if (hit_st == ST_DONE)    hsc_d = HS_ACK + {1'b0, hit_rec};
      else                           hsc_d = HS_NYET;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NT; i++) begin
            st_q[i]  <= ST_FREE;
            age_q[i] <= '0;
            rec_q[i] <= '0;
         end
         key_q <= '0;
         len_q <= '0;
         ovf_q <= 1'b0;
         hsv_q <= 1'b0;
         hsc_q <= HS_NONE;
         uf_q  <= 3'd0;
      end else begin
         for (int i = 0; i < NT; i++) begin
            st_q[i]  <= st_d[i];
            age_q[i] <= age_d[i];
            rec_q[i] <= rec_d[i];
         end
         key_q <= key_d;
         len_q <= len_d;
         ovf_q <= ovf_d;
         hsv_q <= tok_valid;
         hsc_q <= tok_valid ? hsc_d : HS_NONE;
         if (uframe_tick) uf_q <= uf_next;
      end
   end

   assign hs_valid       = hsv_q;
   assign hs_code        = hsc_q;
   assign slot_live      = live;
   assign async_start_ok = aok;
   assign ovf_sticky     = ovf_q;
   assign uf_num         = uf_q;
endmodule

// File: rtl/tt_split_checker.sv
`timescale 1ns/1ps
module tt_split_checker #(
   parameter int PERIODIC_PIPES = 16,
   parameter int ASYNC_PIPES    = 2,
   parameter int NT             = 18,
   parameter int SW             = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          uframe_tick,
   input logic          tok_valid,
   input logic          tok_kind,
   input logic          hs_valid,
   input logic [2:0]    hs_code,
   input logic [NT-1:0] slot_live,
   input logic [1:0]    async_start_ok,
   input logic          ovf_sticky,
   input logic [2:0]    uf_num
);
   a_r10_hs_after_token: assert property (@(posedge clk) disable iff (!rst_n)
      tok_valid |=> hs_valid);
   a_r10_no_stray_hs: assert property (@(posedge clk) disable iff (!rst_n)
      !tok_valid |=> !hs_valid);
   a_r1_start_is_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid && !tok_kind) |=> (hs_code == 3'd0));
   a_r1_alloc_only_by_token: assert property (@(posedge clk) disable iff (!rst_n)
      !tok_valid |=> ((slot_live & ~$past(slot_live)) == '0));
   a_r3_empty_table_timeout: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid && tok_kind && slot_live == '0) |=> (hs_code == 3'd1));
   a_r2_ovf_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_sticky |=> ovf_sticky);
   a_r7_uf_steps: assert property (@(posedge clk) disable iff (!rst_n)
      uframe_tick |=> (uf_num == $past(uf_num) + 3'd1));
   a_r7_uf_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !uframe_tick |=> $stable(uf_num));
   for (genvar j = 0; j < ASYNC_PIPES; j++) begin : g_aok
      a_r9_ok_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
         async_start_ok[j] |-> slot_live[PERIODIC_PIPES + j]);
   end
endmodule

bind tt_split_tracker tt_split_checker #(
   .PERIODIC_PIPES (PERIODIC_PIPES), .ASYNC_PIPES (ASYNC_PIPES), .NT (NT), .SW (SW)
) u_chk (
   .clk (clk), .rst_n (rst_n), .uframe_tick (uframe_tick),
   .tok_valid (tok_valid), .tok_kind (tok_kind),
   .hs_valid (hs_valid), .hs_code (hs_code), .slot_live (slot_live),
   .async_start_ok (async_start_ok), .ovf_sticky (ovf_sticky), .uf_num (uf_num)
);

// File: tb/tt_split_tracker_tb.sv
`timescale 1ns/1ps
module tt_split_tracker_tb;
   localparam int NP = 16;
   localparam int NT = 18;
   localparam int SW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          uframe_tick = 1'b0;
   logic          tok_valid = 1'b0;
   logic          tok_kind = 1'b0;
   logic [6:0]    tok_addr = '0;
   logic [3:0]    tok_ep = '0;
   logic          tok_dir = 1'b0;
   logic [1:0]    tok_type = '0;
   logic [10:0]   tok_len = '0;
   logic          dn_start_valid = 1'b0;
   logic [SW-1:0] dn_start_slot = '0;
   logic          dn_done_valid = 1'b0;
   logic [SW-1:0] dn_done_slot = '0;
   logic [1:0]    dn_done_hs = '0;
   logic [15:0]   bus_time_left = '0;
   logic          hs_valid;
   logic [2:0]    hs_code;
   logic [NT-1:0] slot_live;
   logic [1:0]    async_start_ok;
   logic          ovf_sticky;
   logic [2:0]    uf_num;

   int n_checks = 0;
   int n_fail = 0;

   // reference model state: 0 free, 1 pending, 2 busy, 3 done
   int          m_st  [NT];
   int          m_age [NT];
   int          m_rec [NT];
   logic [13:0] m_key [NT];
   int          m_len [2];
   int          m_uf;
   bit          m_ovf;

   always #4 clk = ~clk;

   tt_split_tracker u_dut (
      .clk (clk), .rst_n (rst_n), .uframe_tick (uframe_tick),
      .tok_valid (tok_valid), .tok_kind (tok_kind), .tok_addr (tok_addr),
      .tok_ep (tok_ep), .tok_dir (tok_dir), .tok_type (tok_type), .tok_len (tok_len),
      .dn_start_valid (dn_start_valid), .dn_start_slot (dn_start_slot),
      .dn_done_valid (dn_done_valid), .dn_done_slot (dn_done_slot),
      .dn_done_hs (dn_done_hs), .bus_time_left (bus_time_left),
      .hs_valid (hs_valid), .hs_code (hs_code), .slot_live (slot_live),
      .async_start_ok (async_start_ok), .ovf_sticky (ovf_sticky), .uf_num (uf_num)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int est_bits(input int len);
      return len * 8 + len / 2 + 64;
   endfunction

   function automatic logic [1:0] m_aok();
      logic [1:0] r;
      for (int j = 0; j < 2; j++)
         r[j] = (m_st[NP + j] == 1) && (est_bits(m_len[j]) <= int'(bus_time_left));
      return r;
   endfunction

   function automatic logic [NT-1:0] m_live();
      logic [NT-1:0] r;
      for (int i = 0; i < NT; i++) r[i] = (m_st[i] != 0);
      return r;
   endfunction

   function automatic string hs_tag(input int c);
      if (c == 0) return "R1";
      if (c == 1) return "R3";
      if (c == 2) return "R4";
      return "R5";
   endfunction

   function automatic int slot_of(input logic [13:0] k);
      for (int i = 0; i < NT; i++) if (m_st[i] != 0 && m_key[i] == k) return i;
      return -1;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < NT; i++) begin
         m_st[i] = 0; m_age[i] = 0; m_rec[i] = 0; m_key[i] = '0;
      end
      m_len[0] = 0; m_len[1] = 0; m_uf = 0; m_ovf = 0;
   endtask

   // applies the requirement rules to the inputs now driven; returns expected code
   task automatic model_step(output int exp_hs);
      int nst [NT];
      int nage [NT];
      int hit;
      logic [13:0] k;
      logic [1:0] ok;
      k = {tok_addr, tok_ep, tok_dir, tok_type};
      ok = m_aok();
      hit = -1;
      exp_hs = 0;
      for (int i = 0; i < NT; i++) begin
         nst[i] = m_st[i]; nage[i] = m_age[i];
         if (hit < 0 && m_st[i] != 0 && m_key[i] == k) hit = i;
      end
      if (uframe_tick) begin
         for (int i = 0; i < NT; i++) begin
            if (m_st[i] != 0) begin
               if (m_age[i] >= 4) nst[i] = 0; else nage[i] = m_age[i] + 1;
               if (i < NP && m_st[i] == 1 && (m_uf == 7 || ((m_uf + 1) % 8) == 6)) nst[i] = 0;
            end
         end
      end
      if (dn_start_valid && int'(dn_start_slot) < NT) begin
         int s = int'(dn_start_slot);
         if (m_st[s] == 1 && (s < NP || ok[s - NP])) begin nst[s] = 2; nage[s] = 0; end
      end
      if (dn_done_valid && int'(dn_done_slot) < NT) begin
         int s = int'(dn_done_slot);
         if (m_st[s] == 2) begin nst[s] = 3; nage[s] = 0; m_rec[s] = int'(dn_done_hs); end
      end
      if (tok_valid) begin
         if (hit >= 0) begin
            nage[hit] = 0;
            nst[hit] = m_st[hit];
            if (tok_kind) begin
               if (m_st[hit] == 3) begin exp_hs = 3 + m_rec[hit]; nst[hit] = 0; end
               else exp_hs = 2;
            end
         end else if (tok_kind) begin
            exp_hs = 1;
         end else begin
            int lo = tok_type[0] ? 0 : NP;
            int hi = tok_type[0] ? NP : NT;
            int f = -1;
            for (int i = lo; i < hi; i++) if (f < 0 && m_st[i] == 0) f = i;
            if (f < 0) m_ovf = 1;
            else begin
               nst[f] = 1; nage[f] = 0; m_rec[f] = 0; m_key[f] = k;
               if (f >= NP) m_len[f - NP] = int'(tok_len);
            end
         end
      end
      for (int i = 0; i < NT; i++) begin m_st[i] = nst[i]; m_age[i] = nage[i]; end
      if (uframe_tick) m_uf = (m_uf + 1) % 8;
   endtask

   task automatic run_cycle(input string tag);
      int exp_hs;
      bit exp_tok;
      exp_tok = tok_valid;
      model_step(exp_hs);
      @(posedge clk);
      @(negedge clk);
      check(hs_valid == exp_tok, "R10", int'(hs_valid), int'(exp_tok));
      if (exp_tok) check(int'(hs_code) == exp_hs, hs_tag(exp_hs), int'(hs_code), exp_hs);
      check(slot_live == m_live(), tag, int'(slot_live), int'(m_live()));
      check(ovf_sticky == m_ovf, "R2", int'(ovf_sticky), int'(m_ovf));
      check(int'(uf_num) == m_uf, "R7", int'(uf_num), m_uf);
      check(async_start_ok == m_aok(), "R9", int'(async_start_ok), int'(m_aok()));
      tok_valid = 0; dn_start_valid = 0; dn_done_valid = 0; uframe_tick = 0;
   endtask

   task automatic set_tok(input bit kind, input int addr, input int ep, input int typ,
                          input int len);
      tok_valid = 1; tok_kind = kind; tok_addr = 7'(addr); tok_ep = 4'(ep);
      tok_dir = 0; tok_type = 2'(typ); tok_len = 11'(len);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      model_reset();
      check(slot_live == '0, "R1", int'(slot_live), 0);
      check(ovf_sticky == 1'b0, "R2", int'(ovf_sticky), 0);
      check(uf_num == 3'd0, "R7", int'(uf_num), 0);
      check(hs_valid == 1'b0, "R10", int'(hs_valid), 0);
   endtask

   task automatic ticks(input int n, input string tag);
      for (int t = 0; t < n; t++) begin uframe_tick = 1; run_cycle(tag); end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      int s;
      void'($urandom(32'h1ACE));
      do_reset();

      // R1: periodic start-split gets slot 0, repeat allocates nothing
      set_tok(0, 1, 1, 1, 0); run_cycle("R1");
      set_tok(0, 1, 1, 1, 0); run_cycle("R1");
      set_tok(1, 1, 1, 1, 0); run_cycle("R4");
      set_tok(1, 9, 2, 3, 0); run_cycle("R3");
      // R6: done on pending slot ignored, then start and NAK
      dn_done_valid = 1; dn_done_slot = 0; dn_done_hs = 1; run_cycle("R6");
      set_tok(1, 1, 1, 1, 0); run_cycle("R4");
      dn_start_valid = 1; dn_start_slot = 0; run_cycle("R6");
      dn_done_valid = 1; dn_done_slot = 0; dn_done_hs = 1; run_cycle("R6");
      set_tok(1, 1, 1, 1, 0); run_cycle("R5");
      set_tok(1, 1, 1, 1, 0); run_cycle("R3");

      // R9: estimate 914 for 100 bytes, threshold exact
      bus_time_left = 16'd913;
      set_tok(0, 5, 0, 2, 100); run_cycle("R9");
      dn_start_valid = 1; dn_start_slot = 5'(NP); run_cycle("R9");
      bus_time_left = 16'd914; run_cycle("R9");
      dn_start_valid = 1; dn_start_slot = 5'(NP); run_cycle("R9");

      // R8: busy async entry survives 4 strobes, dies on 5th
      ticks(4, "R8");
      ticks(1, "R8");
      // R7: pending periodic aborted at microframe 6 (uf now 5)
      set_tok(0, 2, 0, 3, 0); run_cycle("R7");
      ticks(1, "R7");
      // R7: end of frame, pending dropped, busy kept
      ticks(1, "R7");
      set_tok(0, 3, 0, 1, 0); run_cycle("R7");
      set_tok(0, 4, 0, 1, 0); run_cycle("R7");
      s = slot_of({7'd4, 4'd0, 1'b0, 2'd1});
      dn_start_valid = 1; dn_start_slot = 5'(s); run_cycle("R7");
      ticks(1, "R7");
      // R11: async entry at age 4 touched in the strobe cycle survives
      set_tok(0, 6, 0, 0, 10); run_cycle("R11");
      ticks(4, "R11");
      set_tok(1, 6, 0, 0, 10); uframe_tick = 1; run_cycle("R11");
      ticks(1, "R11");

      // R2: fill the periodic partition then overflow
      do_reset();
      for (int a = 0; a < NP; a++) begin set_tok(0, 10 + a, 0, 1, 0); run_cycle("R2"); end
      set_tok(0, 40, 0, 1, 0); run_cycle("R2");
      set_tok(1, 10, 0, 1, 0); run_cycle("R2");
      set_tok(1, 40, 0, 1, 0); run_cycle("R2");

      // constrained random phase
      do_reset();
      for (int n = 0; n < 4000; n++) begin
         int op;
         op = int'($urandom % 10);
         bus_time_left = 16'($urandom % 2000);
         if (op < 5) begin
            set_tok(bit'($urandom % 2), int'($urandom % 3) + 1, int'($urandom % 2),
                    int'($urandom % 4), int'($urandom % 200));
         end else if (op < 8) begin
            int off = int'($urandom % NT);
            s = off;
            for (int i = 0; i < NT; i++) if (m_st[(off + i) % NT] != 0) begin
               s = (off + i) % NT; break;
            end
            if (op < 7) begin dn_start_valid = 1; dn_start_slot = 5'(s); end
            else begin dn_done_valid = 1; dn_done_slot = 5'(s); dn_done_hs = 2'($urandom % 3); end
         end
         if (op >= 8 || ($urandom % 5) == 0) uframe_tick = 1;
         run_cycle("R6");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule